// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that occupies the top eight byte locations of a 32 KiB byte-wide memory space. Software reaches it through a synchronous memory-style port with active-low chip enable, write enable and output enable, a 15-bit address and separate 8-bit data in and data out. Hidden counters keep seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year, all in BCD. They advance once per second. The second is derived from a sub-second tick input divided by a parameter; with a divisor of one, the tick input is a one-pulse-per-second strobe.

The bytes that software sees are plain read/write holding cells. They are copied from the hidden counters one cycle after each second boundary. A control byte can stop that copying in two ways. The read-hold bit freezes the cells so that software reads a snapshot that is consistent. The write-hold bit also freezes them; when it is then cleared, every holding cell is loaded into the counters in one cycle and the sub-second phase restarts. The low six bits of the control byte store a calibration value. A power-good input that is low blocks every write, while the counters keep running.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the clock bytes read seconds 00h, minutes 00h, hours 00h, day of week 01h, date 01h, month 01h, year 00h, and the control byte reads 00h.
- R2: `rd_oe` is 1 exactly when `ce_n`=0, `we_n`=1 and `oe_n`=0; whenever `rd_oe` is 0, `rd_data` is 00h.
- R3: The address map is 7FF8h control, 7FF9h seconds, 7FFAh minutes, 7FFBh hours, 7FFCh day of week (1..7), 7FFDh date, 7FFEh month and 7FFFh year. In the control byte, bit 7 is write-hold, bit 6 is read-hold and bits 5:0 hold a calibration value that reads back unchanged.
- R4: Addresses below 7FF8h read 00h, and writes to them change no clock byte.
- R5: Every TICKS_PER_SEC pulses of `sub_tick` advance the counters by one second. The holding cells show the new value one clock cycle after the counter update when neither hold bit is set.
- R6: Seconds roll over 59 to 00 and carry into minutes, minutes roll over 59 to 00 and carry into hours, and hours roll over 23 to 00 and carry into the day. The day of week steps 7 to 1 on every day rollover.
- R7: The date wraps after day 31 for months 01, 03, 05, 07, 08, 10 and 12, after day 30 for months 04, 06, 09 and 11, and after day 28 for February, or after day 29 when the year is divisible by four. Month 12 wraps to 01, and the year increments from 99 to 00.
- R8: While read-hold is set, the holding cells do not change on second boundaries. After it is cleared, they pick up the counters at the next second.
- R9: While write-hold is set, the holding cells are not refreshed. Clearing write-hold copies all seven holding cells into the counters and restarts the sub-second phase, so the next second occurs after a full TICKS_PER_SEC further ticks.
- R10: While `pwr_ok` is 0, writes to every clock byte and to the control byte are ignored, and the counters and holding-cell refresh keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 00h when no read is active |
| rd_oe | output | 1 | Read data is being driven |
| sub_tick | input | 1 | Sub-second tick strobe, one cycle wide |
| pwr_ok | input | 1 | Supply within tolerance; 0 blocks writes |

## Verification
The bench aims at the calendar carries: midnight with a day-of-week wrap, February in leap and common years, 30-day months and the December 31 roll into year 00. A design that got any of these wrong would show a date such as 02/29 in a common year or a day of week of 08. It also tests the release of each hold bit. A wrong read-hold refreshes the snapshot under the reader or never resumes. A wrong write-hold release leaves the old sub-second phase in place, so the first second after a time set comes early. Writes made while power is low, and writes below the clock window, must leave every byte untouched. A faulty write gate shows up as a corrupted seconds or control byte.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                           dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Step a BCD field, wrapping from last to first
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    return (v == last) ? first : bcd_inc(v);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t next_second(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    n.sec = bcd_step(t.sec, 8'h59, 8'h00);
    if (t.sec == 8'h59) begin
      n.min = bcd_step(t.min, 8'h59, 8'h00);
      if (t.min == 8'h59) begin
        n.hr = bcd_step(t.hr, 8'h23, 8'h00);
        if (t.hr == 8'h23) begin
          n.dow  = bcd_step(t.dow, 8'h07, 8'h01);
          n.date = bcd_step(t.date, month_last_day(t.mon, t.yr), 8'h01);
          if (t.date == month_last_day(t.mon, t.yr)) begin
            n.mon = bcd_step(t.mon, 8'h12, 8'h01);
            if (t.mon == 8'h12) n.yr = bcd_step(t.yr, 8'h99, 8'h00);
          end
        end
      end
    end
    return n;
  endfunction

  // Holding-cell index 1..7 maps to sec, min, hr, dow, date, mon, yr
  function automatic logic [7:0] field_of(input rtc_time_t t, input int idx);
    case (idx)
      1:       return t.sec;
      2:       return t.min;
      3:       return t.hr;
      4:       return t.dow;
      5:       return t.date;
      6:       return t.mon;
      default: return t.yr;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic clr,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase_q;

  assign sec_pulse = sub_tick && !clr && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      phase_q <= '0;
    else if (clr)                    phase_q <= '0;
    else if (sub_tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       now <= RTC_RESET_TIME;
    else if (load)    now <= load_val;
    else if (advance) now <= next_second(now);
  end
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              rd_oe,
  input  logic              sub_tick,
  input  logic              pwr_ok
);
  localparam int CTRL_WHOLD = 7;
  localparam int CTRL_RHOLD = 6;

  logic [7:0] ctrl_q;
  logic [7:0] cell_q [1:7];
  logic       adv_d;
  rtc_time_t  now;
  rtc_time_t  hold_time;

  // Named internal events
  logic       in_window;
  logic [2:0] idx;
  logic       wr_accept;
  logic       load_pulse;
  logic       sec_pulse;
  logic       hold_active;
  logic       refresh_en;

  assign in_window   = &addr[ADDR_W-1:3];
  assign idx         = addr[2:0];
  assign wr_accept   = !ce_n && !we_n && pwr_ok && in_window;
  assign load_pulse  = wr_accept && (idx == 3'd0) && ctrl_q[CTRL_WHOLD] && !wr_data[CTRL_WHOLD];
  assign hold_active = ctrl_q[CTRL_WHOLD] || ctrl_q[CTRL_RHOLD];
  assign refresh_en  = adv_d && !hold_active;
  assign hold_time   = {cell_q[7], cell_q[6], cell_q[5], cell_q[4], cell_q[3], cell_q[2], cell_q[1]};

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .clr(load_pulse), .sec_pulse(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .advance(sec_pulse), .load(load_pulse),
    .load_val(hold_time), .now(now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_d  <= 1'b0;
      ctrl_q <= 8'h00;
    end else begin
      adv_d <= sec_pulse;
      if (wr_accept && idx == 3'd0) ctrl_q <= wr_data;
    end
  end

  for (genvar i = 1; i <= 7; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cell_q[i] <= field_of(RTC_RESET_TIME, i);
      else if (wr_accept && idx == 3'(i))     cell_q[i] <= wr_data;
      else if (refresh_en)                    cell_q[i] <= field_of(now, i);
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (idx)
      3'd0:    rd_mux = ctrl_q;
      3'd1:    rd_mux = cell_q[1];
      3'd2:    rd_mux = cell_q[2];
      3'd3:    rd_mux = cell_q[3];
      3'd4:    rd_mux = cell_q[4];
      3'd5:    rd_mux = cell_q[5];
      3'd6:    rd_mux = cell_q[6];
      default: rd_mux = cell_q[7];
    endcase
  end

  assign rd_oe   = !ce_n && we_n && !oe_n;
  assign rd_data = (rd_oe && in_window) ? rd_mux : 8'h00;
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk #(
  parameter int TICKS_PER_SEC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_ok,
  input logic [7:0] rd_data,
  input logic       rd_oe,
  input logic       wr_accept,
  input logic       sec_pulse,
  input logic       load_pulse,
  input logic       hold_active,
  input logic [7:0] hold_sec,
  input logic [7:0] cnt_sec
);
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> rd_data == 8'h00);

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !wr_accept);

  // R9
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TICKS_PER_SEC > 1 && load_pulse) |=> !sec_pulse);

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !wr_accept) |=> $stable(hold_sec));

  // R5
  sec_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !load_pulse) |=> cnt_sec != $past(cnt_sec));
endmodule

bind rtc_regbank rtc_regbank_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .rd_data(rd_data), .rd_oe(rd_oe),
  .wr_accept(wr_accept), .sec_pulse(sec_pulse), .load_pulse(load_pulse),
  .hold_active(hold_active), .hold_sec(cell_q[1]), .cnt_sec(now.sec)
);

// File: tb/test_rtc_regbank.sv
`timescale 1ns/1ps
module test_rtc_regbank;
  localparam int TPS = 4;
  localparam logic [14:0] A_CTRL = 15'h7FF8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, sub_tick = 1'b0, pwr_ok = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wr_data = '0, rd_data;
  logic        rd_oe;

  int checks = 0, failures = 0;
  int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;

  always #2.5 clk = ~clk;

  rtc_regbank #(.ADDR_W(15), .TICKS_PER_SEC(TPS)) i_rtc_regbank (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe), .sub_tick(sub_tick), .pwr_ok(pwr_ok)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_second();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_w = (m_w == 7) ? 1 : m_w + 1;
          if (m_d == days_in(m_mo, m_y)) begin
            m_d = 1;
            if (m_mo == 12) begin m_mo = 1; m_y = (m_y + 1) % 100; end
            else m_mo++;
          end else m_d++;
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [14:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    #1 d = rd_data;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run_second();
    pulse_ticks(TPS);
    model_second();
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    int exp_v [7];
    exp_v = '{m_s, m_mi, m_h, m_w, m_d, m_mo, m_y};
    for (int i = 0; i < 7; i++) begin
      bus_read(15'h7FF9 + 15'(i), v);
      chk(tag, v, to_bcd(exp_v[i]));
    end
  endtask

  task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
    bus_write(A_CTRL, 8'h80);
    bus_write(15'h7FF9, to_bcd(s));
    bus_write(15'h7FFA, to_bcd(mi));
    bus_write(15'h7FFB, to_bcd(h));
    bus_write(15'h7FFC, to_bcd(w));
    bus_write(15'h7FFD, to_bcd(d));
    bus_write(15'h7FFE, to_bcd(mo));
    bus_write(15'h7FFF, to_bcd(y));
    bus_write(A_CTRL, 8'h00);
    m_y = y; m_mo = mo; m_d = d; m_w = w; m_h = h; m_mi = mi; m_s = s;
  endtask

  initial begin
    #750000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, snap;
    int unsigned seed_init;
    seed_init = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    m_y = 0; m_mo = 1; m_d = 1; m_w = 1; m_h = 0; m_mi = 0; m_s = 0;
    check_all("R1 reset");
    bus_read(A_CTRL, v); chk("R1 ctrl reset", v, 8'h00);

    // R2 gating
    @(negedge clk); addr = 15'h7FFD; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    #1 chk("R2 oe_n high oe flag", {7'd0, rd_oe}, 8'h00); chk("R2 oe_n high data", rd_data, 8'h00);
    oe_n = 1'b0;
    #1 chk("R2 read oe flag", {7'd0, rd_oe}, 8'h01); chk("R2 read data", rd_data, 8'h01);
    ce_n = 1'b1;
    #1 chk("R2 deselect data", rd_data, 8'h00);
    oe_n = 1'b1;

    // R3 calibration readback
    bus_write(A_CTRL, 8'h2A); bus_read(A_CTRL, v); chk("R3 calib", v, 8'h2A);
    bus_write(A_CTRL, 8'h15); bus_read(A_CTRL, v); chk("R3 calib2", v, 8'h15);
    bus_write(A_CTRL, 8'h00);

    // R4 below window
    bus_write(15'h1234, 8'hAA); bus_write(15'h7FF7, 8'h55);
    bus_read(15'h1234, v); chk("R4 low read", v, 8'h00);
    bus_read(15'h7FF7, v); chk("R4 edge read", v, 8'h00);
    check_all("R4 bytes untouched");

    // R5 one second
    pulse_ticks(TPS - 1);
    check_all("R5 partial no advance");
    pulse_ticks(1); model_second();
    check_all("R5 advance");

    // R6 midnight + dow wrap
    set_time(23, 6, 14, 7, 23, 59, 59);
    run_second(); check_all("R6 midnight");
    set_time(23, 6, 14, 3, 10, 59, 59);
    run_second(); check_all("R6 hour carry");

    // R7 month lengths
    set_time(24, 2, 28, 2, 23, 59, 59); run_second(); check_all("R7 leap feb28");
    set_time(24, 2, 29, 2, 23, 59, 59); run_second(); check_all("R7 leap feb29");
    set_time(23, 2, 28, 2, 23, 59, 59); run_second(); check_all("R7 common feb28");
    set_time(23, 4, 30, 2, 23, 59, 59); run_second(); check_all("R7 apr30");
    set_time(23, 1, 31, 2, 23, 59, 59); run_second(); check_all("R7 jan31");
    set_time(99, 12, 31, 5, 23, 59, 59); run_second(); check_all("R7 year wrap");

    // R8 read hold
    set_time(30, 5, 10, 4, 12, 0, 10);
    bus_write(A_CTRL, 8'h40);
    bus_read(15'h7FF9, snap);
    run_second();
    bus_read(15'h7FF9, v); chk("R8 frozen", v, snap);
    bus_write(A_CTRL, 8'h00);
    bus_read(15'h7FF9, v); chk("R8 no resume before tick", v, snap);
    run_second(); check_all("R8 resumed");

    // R9 phase restart on write-hold release
    pulse_ticks(TPS - 1);
    set_time(30, 5, 10, 4, 12, 30, 0);
    pulse_ticks(TPS - 1);
    check_all("R9 phase restarted");
    pulse_ticks(1); model_second();
    check_all("R9 after full second");

    // R10 power-fail write block
    pwr_ok = 1'b0;
    bus_write(15'h7FF9, 8'h33);
    bus_write(A_CTRL, 8'hC0);
    bus_read(A_CTRL, v); chk("R10 ctrl blocked", v, 8'h00);
    check_all("R10 bytes blocked");
    run_second(); check_all("R10 clock runs");
    pwr_ok = 1'b1;

    // Random times near carry boundaries
    for (int it = 0; it < 30; it++) begin
      int y, mo, d, s, mi, h, w, n;
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      d  = days_in(mo, y) - int'($urandom % 2);
      w  = 1 + int'($urandom % 7);
      h  = 22 + int'($urandom % 2);
      mi = 58 + int'($urandom % 2);
      s  = 57 + int'($urandom % 3);
      n  = 1 + int'($urandom % 3);
      set_time(y, mo, d, w, h, mi, s);
      for (int k = 0; k < n; k++) run_second();
      check_all("R6 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule